// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit unsigned operands and a carry-in. It returns a 16-bit sum and a carry-out. The operand width is split into four 4-bit groups. Inside each group, per-bit generate and propagate terms feed a lookahead network. That network forms the group's internal carries and its sum bits. Each group also reduces its bit terms to one group generate and one group propagate.

A second lookahead unit of the same shape takes the four group pairs and the external carry-in. It produces the carry into every group and the final carry-out. As a result, no carry ever travels through a chain of groups.

The arithmetic is combinational. The result lands in output registers that clear on a synchronous active-high reset, so the result appears one clock after the operands are presented. The group width and the group count are parameters. Signed overflow detection and logical operations are not part of the block.

Top module: `hier_cla_adder`

## Requirements
- R1: One clock edge after `op_a`, `op_b` and `carry_in` are sampled (reset low), `{carry_out_q, sum_q}` equals the 17-bit value `op_a + op_b + carry_in`.
- R2: While `rst` is high at a rising edge, `sum_q` becomes 0x0000 and `carry_out_q` becomes 0. They stay at those values for as long as reset is held, whatever the operands are.
- R3: Each bit forms generate = a AND b and propagate = a OR b. Its sum bit is a XOR b XOR the carry that the lookahead logic delivers to that bit.
- R4: A group's generate term forces that group's carry-out to 1. A group's propagate term with group carry-in 1 also forces it to 1. When neither holds, the group's carry-out is 0. Group generate is g3 + p3·g2 + p3·p2·g1 + p3·p2·p1·g0, and group propagate is p3·p2·p1·p0.
- R5: A carry entering bit 0 reaches the carry-out through all four groups. For example, 0xFFFF + 0x0000 + 1 and 0xFFFF + 0x0001 + 0 each give sum 0x0000 with carry-out 1.
- R6: A carry that crosses a group boundary into the top bit gives no carry-out and no extra flag. For example, 0x7FFF + 0x0001 gives sum 0x8000 with carry-out 0.
- R7: With both operands zero, the carry-in alone sets bit 0: the sum is 0x0001 with carry-in 1 and 0x0000 with carry-in 0, and the carry-out is 0 in both cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_q | output | 16 | Registered sum |
| carry_out_q | output | 1 | Registered carry out of bit 15 |

## Verification
The bench targets full-length carry chains, such as all-ones plus one. A design that dropped an inter-group term from the lookahead unit would leave a wrong nibble there, or lose the carry-out. It also uses sums that cross one boundary into the sign bit, such as 0x7FFF + 1. A design with a misrouted group carry would corrupt bit 15 or raise a false carry-out. The carry-in-only cases catch a lookahead network that ignores c0. Random vectors with a fixed seed cover mixed generate and propagate patterns, where a wrong group propagate (for example, an OR in place of an AND) would make carries appear that should not.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int DEF_GROUP_W  = 4;
  localparam int DEF_N_GROUPS = 4;

  typedef struct packed {
    logic gen;
    logic prop;
  } gp_t;
endpackage

// File: rtl/cla_carry_unit.sv
module cla_carry_unit #(
  parameter int N = 4
) (
  input  cla_pkg::gp_t [N-1:0] gp_i,
  input  logic                 c0_i,
  output logic [N:0]           carry_o
);
  // carry into position i+1 is the OR of every generate at or below i,
  // each ANDed with the propagates above it, plus c0 through all propagates
  always_comb begin
    carry_o[0] = c0_i;
    for (int i = 0; i < N; i++) begin
      logic acc;
      logic chain;
      acc   = gp_i[i].gen;
      chain = gp_i[i].prop;
      for (int j = i - 1; j >= 0; j--) begin
        acc   = acc | (chain & gp_i[j].gen);
        chain = chain & gp_i[j].prop;
      end
      carry_o[i+1] = acc | (chain & c0_i);
    end
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          cin_i,
  output logic [GW-1:0] sum_o,
  output cla_pkg::gp_t  grp_o
);
  cla_pkg::gp_t [GW-1:0] bit_gp;
  logic [GW:0]           bit_c;

  // R3: per-bit generate and OR-form propagate
  always_comb begin
    for (int k = 0; k < GW; k++) begin
      bit_gp[k].gen  = a_i[k] & b_i[k];
      bit_gp[k].prop = a_i[k] | b_i[k];
    end
  end

  cla_carry_unit #(.N(GW)) u_bits (
    .gp_i    (bit_gp),
    .c0_i    (cin_i),
    .carry_o (bit_c)
  );

  assign sum_o = a_i ^ b_i ^ bit_c[GW-1:0];

  // R4: group generate and propagate reduced from bit terms
  always_comb begin
    logic acc;
    logic chain;
    acc   = bit_gp[GW-1].gen;
    chain = bit_gp[GW-1].prop;
    for (int j = GW - 2; j >= 0; j--) begin
      acc   = acc | (chain & bit_gp[j].gen);
      chain = chain & bit_gp[j].prop;
    end
    grp_o.gen  = acc;
    grp_o.prop = chain;
  end

  // R4
  always_comb begin
    grp_gen_chk: assert (!grp_o.gen || bit_c[GW]);
  end
  // R4
  always_comb begin
    grp_prop_chk: assert (!(grp_o.prop && cin_i) || bit_c[GW]);
  end
  // R4
  always_comb begin
    grp_kill_chk: assert (grp_o.gen || (grp_o.prop && cin_i) || !bit_c[GW]);
  end
endmodule

// File: rtl/hier_cla_adder.sv
module hier_cla_adder #(
  parameter int GROUP_W  = cla_pkg::DEF_GROUP_W,
  parameter int N_GROUPS = cla_pkg::DEF_N_GROUPS
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [GROUP_W*N_GROUPS-1:0]   op_a,
  input  logic [GROUP_W*N_GROUPS-1:0]   op_b,
  input  logic                          carry_in,
  output logic [GROUP_W*N_GROUPS-1:0]   sum_q,
  output logic                          carry_out_q
);
  localparam int W = GROUP_W * N_GROUPS;

  cla_pkg::gp_t [N_GROUPS-1:0] grp_gp;
  logic [N_GROUPS:0]           grp_c;
  logic [W-1:0]                sum_d;

  generate
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
      cla_group #(.GW(GROUP_W)) u_grp (
        .a_i   (op_a[g*GROUP_W +: GROUP_W]),
        .b_i   (op_b[g*GROUP_W +: GROUP_W]),
        .cin_i (grp_c[g]),
        .sum_o (sum_d[g*GROUP_W +: GROUP_W]),
        .grp_o (grp_gp[g])
      );
    end
  endgenerate

  // second-level lookahead over group terms
  cla_carry_unit #(.N(N_GROUPS)) u_lookahead (
    .gp_i    (grp_gp),
    .c0_i    (carry_in),
    .carry_o (grp_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q       <= '0;
      carry_out_q <= 1'b0;
    end else begin
      sum_q       <= sum_d;
      carry_out_q <= grp_c[N_GROUPS];
    end
  end

  logic [W:0] ref_total;
  assign ref_total = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};

  // R1
  sum_ref_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> {carry_out_q, sum_q} == $past(ref_total));

  // R2
  rst_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (sum_q == '0 && !carry_out_q));

  // R5
  chain_through_chk: assert property (@(posedge clk) disable iff (rst)
    (&(grp_gp[0].prop) && &(op_a ^ op_b) && carry_in) |=> carry_out_q);
endmodule

// File: tb/hier_cla_adder_bench.sv
`timescale 1ns/1ps
module hier_cla_adder_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] sum_q;
  logic         carry_out_q;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  hier_cla_adder u_hier_cla_adder (
    .clk         (clk),
    .rst         (rst),
    .op_a        (op_a),
    .op_b        (op_b),
    .carry_in    (carry_in),
    .sum_q       (sum_q),
    .carry_out_q (carry_out_q)
  );

  function automatic logic [W:0] expect_total(logic [W-1:0] a, logic [W-1:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  task automatic check(string req, logic [W:0] got, logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(string req, logic [W-1:0] a, logic [W-1:0] b, logic c);
    @(negedge clk);
    op_a = a; op_b = b; carry_in = c;
    @(negedge clk);
    check(req, {carry_out_q, sum_q}, expect_total(a, b, c));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    op_a = 16'hFFFF; op_b = 16'h0001; carry_in = 1'b1;
    @(negedge clk);
    // R2: outputs stay cleared under reset despite live operands
    check("R2", {carry_out_q, sum_q}, 17'h0);
    @(negedge clk);
    check("R2", {carry_out_q, sum_q}, 17'h0);
    rst = 1'b0;

    // R7: carry-in alone
    apply("R7", 16'h0000, 16'h0000, 1'b1);
    apply("R7", 16'h0000, 16'h0000, 1'b0);
    // R5: full-length chain
    apply("R5", 16'hFFFF, 16'h0000, 1'b1);
    apply("R5", 16'hFFFF, 16'h0001, 1'b0);
    apply("R5", 16'hFFFF, 16'hFFFF, 1'b1);
    // R6: carry into the top bit without carry-out
    apply("R6", 16'h7FFF, 16'h0001, 1'b0);
    apply("R6", 16'h0FFF, 16'h0001, 1'b0);
    // R4: group generate and group propagate patterns
    apply("R4", 16'h0008, 16'h0008, 1'b0);
    apply("R4", 16'h00F0, 16'h000F, 1'b1);
    apply("R4", 16'h5555, 16'hAAAA, 1'b0);
    // R3: per-bit sums without carries
    apply("R3", 16'h1234, 16'h4000, 1'b0);
    // R1: random vectors
    for (int n = 0; n < 400; n++) begin
      apply("R1", W'($urandom), W'($urandom), 1'($urandom));
    end

    // R2: reset clears a nonzero result
    apply("R1", 16'hFFFF, 16'hFFFF, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R2", {carry_out_q, sum_q}, 17'h0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule